// File: doc/BRIEF.md
# Non-overlap pattern pulse generator

The block drives an 8-bit parallel pattern, organised as two 4-bit groups, from a free-running up-counter. A period compare value sets the length of each output cycle and a second, smaller delay compare value sets a dead time inside it. At each period boundary, bits that must go low do so at once. Bits that must go high wait until the delay match. Complementary phases driven from one group therefore never overlap.

Software or a DMA engine feeds the next pattern into a staging register. A single-cycle request pulse, raised at the delay match, marks the point from which the staging register may be loaded for the following cycle. Repeating four staged patterns in order gives a four-phase complementary drive with a dead time between the phases. Each group can also run without the dead time. Each bit can be frozen through an output-enable mask.

Top module: `nov_pulse_gen`

## Requirements
- R1: After reset `cnt_o` is 0. While running, it counts up by one per clock. In the clock after it reads a value greater than or equal to the period register, it reads 0, so with period P it runs 0..P.
- R2: Register map, written through `wr_en_i`/`wr_addr_i`/`wr_data_i` and taking effect at the next clock: address 0 holds the period; address 1 holds the delay; address 2 holds the staged pattern (bits 7:0); address 3 holds the per-bit output enable (bits 7:0); address 4 is control, with bit 0 run, bit 1 request enable, bit 2 dead-time mode for bits 3:0 and bit 3 dead-time mode for bits 7:4; address 5 is status, where writing bit 0 as 1 clears the flag. All registers and `pat_o` reset to 0.
- R3: In a group in dead-time mode, the period match clears every enabled bit that is 1 in `pat_o` and 0 in the staged pattern. This is visible when `cnt_o` reads 0. No bit rises at that point.
- R4: In a group in dead-time mode, enabled bits that are 0 in `pat_o` and 1 in the staged pattern rise when `cnt_o` reads delay+1. `pat_o` does not change between the period match and that point.
- R5: A group not in dead-time mode takes every enabled staged bit, rising or falling, at the period match. The result is visible when `cnt_o` reads 0.
- R6: Bits whose output-enable bit is 0 keep their value through all transfers.
- R7: The delay match sets `flag_o`, whether or not requests are enabled. The flag stays set until status bit 0 is written as 1. A set in the same cycle as a clear wins.
- R8: When requests are enabled, `req_o` is high for exactly one clock, in the cycle where `cnt_o` reads delay+1. With requests disabled it stays low.
- R9: If the delay is greater than or equal to the period, no delay match occurs. No bit rises, and neither `req_o` nor `flag_o` is raised, while falling bits still apply at the period match.
- R10: With both groups in dead-time mode, staging 0x95, 0x65, 0x59, 0x56, 0x95 at successive requests makes `pat_o` take each value in turn. In between, it shows the AND of the old and new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| pat_o | output | 8 | Pattern output |
| req_o | output | 1 | One-cycle request for the next pattern |
| flag_o | output | 1 | Sticky delay-match flag |
| cnt_o | output | 16 | Current counter value |

## Verification
The one-cycle request check assumes the delay register is not rewritten during a run to the value the counter is about to reach. The bench rewrites the delay only once, moving it to the period value, which disables matches. The edge-origin checks assume that the dead-time mode and output enables change only as the bench orders. The bench performs every such write well away from a period or delay match, because it waits on `cnt_o` values before each write. Period and delay are always nonzero, and the delay stays below the period except in the R9 test.

// File: rtl/nov_pkg.sv
package nov_pkg;
  typedef enum logic [2:0] {
    ADDR_PERIOD = 3'd0,
    ADDR_DELAY  = 3'd1,
    ADDR_NEXT   = 3'd2,
    ADDR_OE     = 3'd3,
    ADDR_CTRL   = 3'd4,
    ADDR_STAT   = 3'd5
  } reg_addr_e;

  localparam int unsigned CTRL_RUN     = 0;
  localparam int unsigned CTRL_REQ_EN  = 1;
  localparam int unsigned CTRL_NOV_LSB = 2;
  localparam int unsigned STAT_CLR     = 0;
endpackage

// File: rtl/nov_regs.sv
module nov_regs
  import nov_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PAT_W = 8,
  parameter int unsigned N_GRP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             match_a_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] delay_o,
  output logic [PAT_W-1:0] next_o,
  output logic [PAT_W-1:0] oe_o,
  output logic [N_GRP-1:0] nov_en_o,
  output logic             run_o,
  output logic             req_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] period_q, delay_q;
  logic [PAT_W-1:0] next_q, oe_q;
  logic [N_GRP-1:0] nov_q;
  logic             run_q, req_en_q, flag_q, req_q;
  logic             clr_flag;

  assign clr_flag = wr_en_i && (wr_addr_i == ADDR_STAT) && wr_data_i[STAT_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      delay_q  <= '0;
      next_q   <= '0;
      oe_q     <= '0;
      nov_q    <= '0;
      run_q    <= 1'b0;
      req_en_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_PERIOD: period_q <= wr_data_i;
        ADDR_DELAY:  delay_q  <= wr_data_i;
        ADDR_NEXT:   next_q   <= wr_data_i[PAT_W-1:0];
        ADDR_OE:     oe_q     <= wr_data_i[PAT_W-1:0];
        ADDR_CTRL: begin
          run_q    <= wr_data_i[CTRL_RUN];
          req_en_q <= wr_data_i[CTRL_REQ_EN];
          nov_q    <= wr_data_i[CTRL_NOV_LSB +: N_GRP];
        end
        default: ;
      endcase
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= match_a_i && req_en_q;
      if (match_a_i)     flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end

  assign period_o = period_q;
  assign delay_o  = delay_q;
  assign next_o   = next_q;
  assign oe_o     = oe_q;
  assign nov_en_o = nov_q;
  assign run_o    = run_q;
  assign req_o    = req_q;
  assign flag_o   = flag_q;

  assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(match_a_i) |-> flag_q);
  assert_req_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  assert_req_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> $past(match_a_i) && $past(req_en_q));
endmodule

// File: rtl/nov_timer.sv
module nov_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_a_o,
  output logic             match_b_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             delay_legal;

  assign delay_legal = delay_i < period_i;
  assign match_b_o   = run_i && (cnt_q >= period_i);
  assign match_a_o   = run_i && delay_legal && (cnt_q == delay_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (match_b_o) cnt_q <= '0;
    else if (run_i)     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  assert_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(match_b_o) |-> cnt_q == '0);
  assert_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) && !$past(match_b_o) |-> cnt_q == $past(cnt_q) + CNT_W'(1));
  assert_match_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(match_a_o && match_b_o));
endmodule

// File: rtl/nov_group.sv
module nov_group #(
  parameter int unsigned GRP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             match_a_i,
  input  logic             match_b_i,
  input  logic             nov_en_i,
  input  logic [GRP_W-1:0] next_i,
  input  logic [GRP_W-1:0] oe_i,
  output logic [GRP_W-1:0] pat_o
);
  logic [GRP_W-1:0] pat_q, pat_d, fall_m, rise_m;

  assign fall_m = oe_i & pat_q & ~next_i;
  assign rise_m = oe_i & ~pat_q & next_i;

  always_comb begin
    pat_d = pat_q;
    if (match_b_i) begin
      pat_d = pat_q & ~fall_m;
      if (!nov_en_i) pat_d = pat_d | rise_m;
    end else if (match_a_i && nov_en_i) begin
      pat_d = pat_q | rise_m;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pat_q <= '0;
    else         pat_q <= pat_d;
  end

  assign pat_o = pat_q;

  for (genvar b = 0; b < GRP_W; b++) begin : g_bit_chk
    assert_fall_on_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pat_q[b]) |-> $past(match_b_i));
    assert_rise_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pat_q[b]) |-> ($past(match_a_i) && $past(nov_en_i)) ||
                          ($past(match_b_i) && !$past(nov_en_i)));
    assert_hold_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(oe_i[b]) |-> $stable(pat_q[b]));
  end
endmodule

// File: rtl/nov_pulse_gen.sv
module nov_pulse_gen #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned GRP_W = 4,
  parameter int unsigned N_GRP = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [2:0]               wr_addr_i,
  input  logic [CNT_W-1:0]         wr_data_i,
  output logic [GRP_W*N_GRP-1:0]   pat_o,
  output logic                     req_o,
  output logic                     flag_o,
  output logic [CNT_W-1:0]         cnt_o
);
  localparam int unsigned PAT_W = GRP_W * N_GRP;

  logic [CNT_W-1:0] period, delay;
  logic [PAT_W-1:0] next_pat, oe;
  logic [N_GRP-1:0] nov_en;
  logic             run, match_a, match_b;

  nov_regs #(.CNT_W(CNT_W), .PAT_W(PAT_W), .N_GRP(N_GRP)) regs_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .match_a_i (match_a),
    .period_o  (period),
    .delay_o   (delay),
    .next_o    (next_pat),
    .oe_o      (oe),
    .nov_en_o  (nov_en),
    .run_o     (run),
    .req_o     (req_o),
    .flag_o    (flag_o)
  );

  nov_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_i, .rst_ni,
    .run_i     (run),
    .period_i  (period),
    .delay_i   (delay),
    .cnt_o     (cnt_o),
    .match_a_o (match_a),
    .match_b_o (match_b)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    nov_group #(.GRP_W(GRP_W)) grp_i (
      .clk_i, .rst_ni,
      .match_a_i (match_a),
      .match_b_i (match_b),
      .nov_en_i  (nov_en[g]),
      .next_i    (next_pat[g*GRP_W +: GRP_W]),
      .oe_i      (oe[g*GRP_W +: GRP_W]),
      .pat_o     (pat_o[g*GRP_W +: GRP_W])
    );
  end

  assert_req_on_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> cnt_o == delay + CNT_W'(1));
  assert_no_req_bad_delay_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(delay >= period) && $past(delay) == delay && $past(period) == period |-> !req_o);
endmodule

// File: tb/nov_pulse_gen_tb_top.sv
module nov_pulse_gen_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned P = 9;
  localparam int unsigned D = 3;
  localparam logic [7:0] SEQ [5] = '{8'h95, 8'h65, 8'h59, 8'h56, 8'h95};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [7:0]  pat_o;
  logic        req_o, flag_o;
  logic [15:0] cnt_o;

  int unsigned n_run = 0, n_fail = 0, n_req = 0;
  bit          done = 1'b0;

  nov_pulse_gen dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .pat_o, .req_o, .flag_o, .cnt_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(negedge clk_i) if (req_o) n_req++;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    int unsigned guard = 0;
    do begin
      @(negedge clk_i);
      guard++;
    end while (cnt_o !== v && guard < 1000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] prev, nxt;
    int unsigned r0;
    repeat (3) @(negedge clk_i);
    check({pat_o, req_o, flag_o}, 32'h0, "R2 reset outputs");
    check(cnt_o, 0, "R1 reset count");
    rst_ni = 1'b1;
    @(negedge clk_i);
    wr(3'd0, 16'(P));
    wr(3'd1, 16'(D));
    wr(3'd3, 16'h00FF);
    wr(3'd2, {8'h0, SEQ[0]});
    wr(3'd4, 16'h000F); // run, req enable, both groups dead-time
    wait_cnt(16'(D + 1));
    check(pat_o, SEQ[0], "R4 first rise");
    check(req_o, 1, "R8 first request");

    // table walk: four-phase sequence
    for (int i = 1; i < 5; i++) begin
      prev = SEQ[i-1]; nxt = SEQ[i];
      wr(3'd2, {8'h0, nxt});
      wait_cnt(16'(P));
      check(pat_o, prev, "R3 no change before period match");
      wait_cnt(0);
      check(pat_o, prev & nxt, "R10 falls only at period match");
      wait_cnt(16'(D));
      check(pat_o, prev & nxt, "R4 rise held back");
      wait_cnt(16'(D + 1));
      check(pat_o, nxt, "R10 full pattern after delay");
      check(req_o, 1, "R8 request with rise");
      @(negedge clk_i);
      check(req_o, 0, "R8 request one cycle");
    end

    // counter wrap
    wait_cnt(16'(P));
    @(negedge clk_i);
    check(cnt_o, 0, "R1 wrap after period");

    // flag clear
    check(flag_o, 1, "R7 flag set");
    wr(3'd5, 16'h0001);
    check(flag_o, 0, "R7 flag cleared");

    // requests disabled
    wr(3'd4, 16'h000D);
    wr(3'd2, 16'h0065);
    r0 = n_req;
    wait_cnt(0);
    wait_cnt(16'(D + 1));
    check(pat_o, 8'h65, "R8 pattern without request");
    check(n_req, r0, "R8 no request when disabled");
    check(flag_o, 1, "R7 flag set without request enable");

    // upper group without dead time
    wr(3'd4, 16'h0007);
    wr(3'd2, 16'h0059);
    wait_cnt(0);
    check(pat_o, 8'h51, "R5 plain group takes all at period");
    wait_cnt(16'(D + 1));
    check(pat_o, 8'h59, "R5 dead-time group rises later");

    // low nibble masked
    wr(3'd4, 16'h000F);
    wr(3'd3, 16'h00F0);
    wr(3'd2, 16'h00A6);
    wait_cnt(0);
    check(pat_o, 8'h09, "R6 masked bits hold at period");
    wait_cnt(16'(D + 1));
    check(pat_o, 8'hA9, "R6 masked bits hold at delay");
    wr(3'd3, 16'h00FF);

    // delay equal to period
    wr(3'd1, 16'(P));
    wr(3'd5, 16'h0001);
    wr(3'd2, 16'h0056);
    r0 = n_req;
    wait_cnt(0);
    check(pat_o, 8'h00, "R9 falls still apply");
    wait_cnt(16'(D + 1));
    check(pat_o, 8'h00, "R9 no rise at old delay");
    wait_cnt(16'(P));
    wait_cnt(16'(D + 1));
    check(pat_o, 8'h00, "R9 no rise next period");
    check(n_req, r0, "R9 no request");
    check(flag_o, 0, "R9 flag stays clear");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule